// File: doc/BRIEF.md
# Frame Phase Status Sampler

This block measures where a 4.096 MHz serial-side clock sits relative to the frames of a parallel port, and it gives that measurement to a CPU. It runs in the system clock domain. It receives the serial clock as two signals: a level that shows the clock's current phase, and a one-cycle tick for each serial clock cycle. A running measurement word is kept up to date at all times. That word holds three things: the sampled clock phase, a count of serial cycles since the last serial frame sync, and a parity bit that flips on every serial frame.

On every second parallel frame pulse (every 250 µs when the parallel frames come at 125 µs), the whole word is copied into a snapshot register in a single clock edge. An input flag selects between alternate-pulse capture and capture on every pulse. The CPU reads the 11-bit snapshot through two read-only byte addresses. The low byte comes from address 8 and the top three bits from address 9. Software normally reads twice to avoid a pair of bytes that straddles a capture, but no single byte can ever mix two snapshots.

Top module: `frame_phase_sampler`

## Requirements
- R1: While `rst` is high at a clock edge, the cycle count, the frame parity, the phase bit, the alternate-pulse divider and the snapshot all become zero, so every read returns 0 after reset.
- R2: Bit 0 of the measurement word is `ser_phase` as registered at the previous clock edge.
- R3: Bits 9..1 of the measurement word count the clock edges at which `ser_tick` is high and `ser_fsync` is low. The count wraps from 511 to 0. It holds when neither input is high.
- R4: At an edge where `ser_fsync` is high, the count goes to zero and bit 10 (the frame parity) inverts. This takes priority over `ser_tick`.
- R5: When `alt_en` is 1, the parallel frame pulses `par_fp` alternate between skipped and captured, starting with a skip after reset. A captured pulse copies the measurement word as it stood before that edge.
- R6: When `alt_en` is 0, every `par_fp` captures, and the divider is held cleared. After `alt_en` returns to 1, the next pulse is skipped.
- R7: With `rd_en` high and `rd_addr` equal to 8, `rd_data` shows snapshot bits 7..0 in the same cycle.
- R8: With `rd_en` high and `rd_addr` equal to 9, `rd_data[2:0]` shows snapshot bits 10..8 and `rd_data[7:3]` reads as zero.
- R9: `rd_data` is zero when `rd_en` is low, and for any address other than 8 or 9. Reads never change any state.
- R10: The snapshot changes only at an edge with a capturing `par_fp`. All 11 bits change at that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_phase | input | 1 | Current level of the 4.096 MHz serial clock |
| ser_tick | input | 1 | One-cycle pulse per serial clock cycle |
| ser_fsync | input | 1 | Serial frame sync pulse |
| par_fp | input | 1 | Parallel frame pulse |
| alt_en | input | 1 | 1: capture on alternate pulses, 0: capture on every pulse |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | 4 | CPU register address |
| rd_data | output | 8 | CPU read data (combinational) |

## Verification
The bench builds the block with its default parameters: a 9-bit cycle count, a 4-bit register address, and the status bytes based at address 8. With these values a run of about 600 back-to-back ticks takes the count through its 511-to-0 wrap, and the unused addresses 0..7 and 10..15 can all be reached to check that they read zero. The frame pulse periods are kept short so that many skip/capture pairs occur. The `alt_en` flag is switched in the middle of a run to exercise the divider clear. A random phase mixes in collisions of sync and tick, and pulses on back-to-back cycles.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int CYC_W    = 9;
    localparam int STATUS_W = CYC_W + 2;
    localparam int BYTE_W   = 8;

    typedef struct packed {
        logic             parity;
        logic [CYC_W-1:0] cycles;
        logic             phase;
    } phase_word_t;

    function automatic phase_word_t make_word(input logic par,
                                              input logic [CYC_W-1:0] cyc,
                                              input logic ph);
        phase_word_t w;
        w.parity = par;
        w.cycles = cyc;
        w.phase  = ph;
        return w;
    endfunction

endpackage

// File: rtl/fps_phase_counter.sv
module fps_phase_counter
    import fps_pkg::*;
#(
    parameter int CW = CYC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser_phase,
    input  logic          ser_tick,
    input  logic          ser_fsync,
    output logic [CW-1:0] cnt_q,
    output logic          parity_q,
    output logic          phase_q
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            parity_q <= 1'b0;
            phase_q  <= 1'b0;
        end else begin
            phase_q <= ser_phase;
            if (ser_fsync) begin
                cnt_q    <= '0;
                parity_q <= ~parity_q;
            end else if (ser_tick) begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

endmodule

// File: rtl/fps_frame_divider.sv
module fps_frame_divider (
    input  logic clk,
    input  logic rst,
    input  logic par_fp,
    input  logic alt_en,
    output logic div_q,
    output logic capture
);

    assign capture = par_fp && (!alt_en || div_q);

    always_ff @(posedge clk) begin
        if (rst || !alt_en) begin
            div_q <= 1'b0;
        end else if (par_fp) begin
            div_q <= ~div_q;
        end
    end

endmodule

// File: rtl/fps_capture.sv
module fps_capture
    import fps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        capture,
    input  phase_word_t live,
    output phase_word_t snap_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (capture) begin
            snap_q <= live;
        end
    end

endmodule

// File: rtl/fps_read_port.sv
module fps_read_port
    import fps_pkg::*;
#(
    parameter int AW        = 4,
    parameter int BASE_ADDR = 8,
    parameter int WORD_W    = STATUS_W
) (
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int NLANE = (WORD_W + BYTE_W - 1) / BYTE_W;
    localparam int PAD_W = NLANE * BYTE_W;

    logic [PAD_W-1:0]  padded;
    logic [NLANE-1:0]  hit;
    logic [BYTE_W-1:0] lane_data [NLANE];

    assign padded = PAD_W'(word);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign hit[i]       = rd_en && (rd_addr == AW'(BASE_ADDR + i));
        assign lane_data[i] = padded[i*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NLANE; i++) begin
            if (hit[i]) rd_data = rd_data | lane_data[i];
        end
    end

endmodule

// File: rtl/frame_phase_sampler.sv
module frame_phase_sampler
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_phase,
    input  logic              ser_tick,
    input  logic              ser_fsync,
    input  logic              par_fp,
    input  logic              alt_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [CYC_W-1:0] cnt_q;
    logic             parity_q;
    logic             phase_q;
    logic             div_q;
    logic             capture;
    phase_word_t      live;
    phase_word_t      snap_q;

    fps_phase_counter #(.CW(CYC_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .ser_phase (ser_phase),
        .ser_tick  (ser_tick),
        .ser_fsync (ser_fsync),
        .cnt_q     (cnt_q),
        .parity_q  (parity_q),
        .phase_q   (phase_q)
    );

    assign live = make_word(parity_q, cnt_q, phase_q);

    fps_frame_divider u_divider (
        .clk     (clk),
        .rst     (rst),
        .par_fp  (par_fp),
        .alt_en  (alt_en),
        .div_q   (div_q),
        .capture (capture)
    );

    fps_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .live    (live),
        .snap_q  (snap_q)
    );

    fps_read_port #(
        .AW        (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .WORD_W    (STATUS_W)
    ) u_read (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .word    (snap_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/fps_checker.sv
module fps_checker
    import fps_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ser_phase,
    input logic              ser_tick,
    input logic              ser_fsync,
    input logic              par_fp,
    input logic              alt_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CYC_W-1:0]  cnt_q,
    input logic              parity_q,
    input logic              phase_q,
    input logic              div_q,
    input logic [STATUS_W-1:0] snap_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !parity_q && !phase_q && !div_q && snap_q == '0)); // R1

    AST_PHASE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_q == $past(ser_phase)); // R2

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (ser_tick && !ser_fsync) |=> cnt_q == $past(cnt_q) + CYC_W'(1)); // R3

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ser_tick && !ser_fsync) |=> $stable(cnt_q)); // R3

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ser_fsync |=> (cnt_q == '0 && parity_q != $past(parity_q))); // R4

    AST_SKIP_ODD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (par_fp && alt_en && !div_q) |=> $stable(snap_q)); // R5

    AST_EVERY_PULSE: assert property (@(posedge clk) disable iff (rst)
        (par_fp && !alt_en) |=> snap_q == {$past(parity_q), $past(cnt_q), $past(phase_q)}); // R6

    AST_HIGH_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_W'(BASE_ADDR + 1)) |-> rd_data[7:3] == 5'd0); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0); // R9

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
        !par_fp |=> $stable(snap_q)); // R10

endmodule

bind frame_phase_sampler fps_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_fps_checker (
    .clk       (clk),
    .rst       (rst),
    .ser_phase (ser_phase),
    .ser_tick  (ser_tick),
    .ser_fsync (ser_fsync),
    .par_fp    (par_fp),
    .alt_en    (alt_en),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cnt_q     (cnt_q),
    .parity_q  (parity_q),
    .phase_q   (phase_q),
    .div_q     (div_q),
    .snap_q    (snap_q)
);

// File: tb/test_frame_phase_sampler.sv
module test_frame_phase_sampler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_phase = 1'b0;
    logic       ser_tick = 1'b0;
    logic       ser_fsync = 1'b0;
    logic       par_fp = 1'b0;
    logic       alt_en = 1'b1;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt = 0, m_par = 0, m_ph = 0, m_div = 0, m_snap = 0;

    always #2.5 clk = ~clk;

    frame_phase_sampler i_frame_phase_sampler (
        .clk (clk), .rst (rst), .ser_phase (ser_phase), .ser_tick (ser_tick),
        .ser_fsync (ser_fsync), .par_fp (par_fp), .alt_en (alt_en),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    function automatic int expect_read(input bit en, input int addr);
        if (!en) return 0;
        if (addr == 8) return m_snap & 255;
        if (addr == 9) return (m_snap >> 8) & 7;
        return 0;
    endfunction

    task automatic check_read(input string req);
        int exp_v;
        exp_v = expect_read(rd_en, int'(rd_addr));
        checks++;
        if (int'(rd_data) != exp_v) begin
            failures++;
            $display("FAIL %s addr=%0d en=%0b actual=%0h expected=%0h",
                     req, rd_addr, rd_en, rd_data, exp_v);
        end
    endtask

    function automatic string req_for(input bit en, input int addr, input string tag);
        if (!en || (addr != 8 && addr != 9)) return {"R9 ", tag};
        if (addr == 8) return {"R7 ", tag};
        return {"R8 ", tag};
    endfunction

    // one clock: inputs were set at negedge, check comb read, then model the edge
    task automatic step(input string tag);
        #1;
        check_read(req_for(rd_en, int'(rd_addr), tag));
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_par = 0; m_ph = 0; m_div = 0; m_snap = 0;
        end else begin
            if (par_fp && (!alt_en || m_div != 0))
                m_snap = (m_par << 10) | (m_cnt << 1) | m_ph;
            if (!alt_en) m_div = 0;
            else if (par_fp) m_div = 1 - m_div;
            if (ser_fsync) begin
                m_cnt = 0; m_par = 1 - m_par;
            end else if (ser_tick) begin
                m_cnt = (m_cnt + 1) % 512;
            end
            m_ph = int'(ser_phase);
        end
        @(negedge clk);
    endtask

    task automatic set_read(input int k);
        int sel;
        sel = k % 5;
        rd_en   = (sel != 4);
        rd_addr = (sel == 0) ? 4'd8 : (sel == 1) ? 4'd9 : (sel == 2) ? 4'd8 :
                  (sel == 3) ? 4'(k % 16) : 4'd9;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset clears state, all reads zero
        rd_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ser_tick = 1'b1; ser_fsync = 1'b1; par_fp = 1'b1; ser_phase = 1'b1;
            rd_addr = 4'(8 + (i % 2));
            step("R1 reset");
        end
        rst = 1'b0; ser_tick = 0; ser_fsync = 0; par_fp = 0; ser_phase = 0;
        rd_addr = 4'd8;
        step("R1 after reset");
        rd_addr = 4'd9;
        step("R1 after reset");

        // R2 R3 R5: ticks every cycle (wrap past 511), alternate capture
        alt_en = 1'b1;
        for (int k = 0; k < 1500; k++) begin
            ser_tick  = 1'b1;
            ser_phase = (k % 3) == 0;
            ser_fsync = (k % 1400) == 1399;
            par_fp    = (k % 37) == 5;
            set_read(k);
            step("R2 R3 R5 wrap");
        end

        // R4: frequent sync, sparse ticks, sync colliding with ticks
        for (int k = 0; k < 800; k++) begin
            ser_tick  = (k % 4) != 0;
            ser_phase = (k % 2) == 0;
            ser_fsync = (k % 61) == 30;
            par_fp    = (k % 13) == 7;
            set_read(k);
            step("R4 sync");
        end

        // R6: every pulse captures, then back to alternate
        alt_en = 1'b0;
        for (int k = 0; k < 400; k++) begin
            ser_tick  = (k % 2) == 0;
            ser_phase = (k % 5) < 2;
            ser_fsync = (k % 97) == 50;
            par_fp    = (k % 11) == 3;
            set_read(k);
            step("R6 every");
        end
        alt_en = 1'b1;
        for (int k = 0; k < 300; k++) begin
            ser_tick  = 1'b1;
            ser_phase = (k % 2) == 1;
            ser_fsync = 1'b0;
            par_fp    = (k % 17) == 2;
            set_read(k);
            step("R6 re-enable");
        end

        // R10 and mixed: random stimulus with back-to-back pulses and idle reads
        for (int k = 0; k < 3000; k++) begin
            ser_tick  = $urandom_range(0, 1) == 1;
            ser_phase = $urandom_range(0, 1) == 1;
            ser_fsync = $urandom_range(0, 40) == 0;
            par_fp    = $urandom_range(0, 6) == 0;
            if ((k % 500) == 250) alt_en = ~alt_en;
            rd_en     = $urandom_range(0, 5) != 0;
            rd_addr   = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15))
                                                    : 4'(8 + $urandom_range(0, 1));
            step("R10 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule